// File: doc/BRIEF.md
# MSI interrupt capture controller

This block sits on the inbound memory-write path of a PCIe-style link and picks out message-signalled interrupts. Software programs a 64-bit target address. Every inbound write whose full address equals that target is consumed as an interrupt message. Every other write is forwarded unchanged in the same cycle. The 32-bit payload of a captured write is read directly as a vector number. That number selects a bank of 32 vectors and a bit within the bank.

Each bank has three 32-bit registers: an enable word, a mask word and a status word. A vector is latched into status only while its enable bit is set. The mask gates only the interrupt line. Status bits clear when software writes a 1 to them. One active-high interrupt line tells the host that some unmasked status bit is pending. Software reaches every register through a simple word-wide port. Writes take effect at the clock edge, and reads return data combinationally for the presented offset.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset, both target words and every bank's enable, mask and status words read as 0, and `irq` is low.
- R2: The target address low word is read and written at offset 0x820, and the high word at offset 0x824.
- R3: Bank b's enable word is at 0x828+12*b, its mask word at 0x82C+12*b and its status word at 0x830+12*b, for b = 0..7. Enable and mask read back what was written. A write to status never sets a bit.
- R4: An inbound write with `in_valid` high is an interrupt message only when `in_addr` equals {high word, low word}. In that case `pass_valid` is low in that cycle. Any other inbound write appears on `pass_valid`/`pass_addr`/`pass_data` in the same cycle with address and data unchanged.
- R5: A captured message with data n (0 <= n < 256) sets bit n%32 of bank n/32's status word at the clock edge that samples it, provided that bank's enable bit n%32 is set.
- R6: A captured vector whose enable bit is clear leaves status unchanged.
- R7: Writing a status word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R8: `irq` is high exactly while some bank has a bit that is 1 in status and 0 in mask. A masked vector still sets its status bit.
- R9: A captured message whose data is 256 or more changes no status bit in any bank.
- R10: When a vector arrives in the same cycle that software clears that same status bit, the bit is 1 afterwards. Clearing a different bit in that cycle still takes effect.
- R11: Reads of offsets outside the target words and the bank registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound memory write present this cycle |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| pass_valid | output | 1 | Forwarded non-interrupt write present |
| pass_addr | output | 64 | Forwarded write address |
| pass_data | output | 32 | Forwarded write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Host interrupt, high while an unmasked vector is pending |

## Verification
The hardest situation to reach from the ports is a collision between an arriving vector and a software clear of that same status bit in a single cycle. If the ordering inside the status update is wrong, the bit disappears silently. The bench drives the inbound message and the status write on the same falling edge, so one rising edge samples both. It then repeats the collision with a clear of a neighbouring bit, to show that the clear is still honoured. Out-of-range vectors whose low five bits match an enabled bit are also sent, which exposes any decode that truncates the vector number.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam int REG_AW      = 12;
    localparam int WORD_W      = 32;
    localparam int MADDR_W     = 64;
    localparam int VEC_PER_BNK = 32;

    localparam logic [REG_AW-1:0] OFS_TGT_LO = 12'h820;
    localparam logic [REG_AW-1:0] OFS_TGT_HI = 12'h824;
    localparam int                OFS_BANK0  = 'h828;
    localparam int                BNK_STRIDE = 12;

    typedef enum logic [1:0] {
        FLD_ENABLE = 2'd0,
        FLD_MASK   = 2'd1,
        FLD_STATUS = 2'd2
    } bank_field_e;

    typedef struct packed {
        logic               valid;
        logic [MADDR_W-1:0] addr;
        logic [WORD_W-1:0]  data;
    } mem_wr_t;

    typedef struct packed {
        logic              we;
        logic [REG_AW-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } reg_wr_t;

    function automatic logic [REG_AW-1:0] bank_reg_ofs(input int bank, input bank_field_e fld);
        int ofs;
        ofs = OFS_BANK0 + BNK_STRIDE * bank + 4 * int'(fld);
        return ofs[REG_AW-1:0];
    endfunction

endpackage

// File: rtl/msi_target_match.sv
module msi_target_match
    import msi_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           cfg,
    input  mem_wr_t           inb,
    output mem_wr_t           fwd,
    output logic              msg_hit,
    output logic [WORD_W-1:0] tgt_lo,
    output logic [WORD_W-1:0] tgt_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_lo <= '0;
            tgt_hi <= '0;
        end else if (cfg.we) begin
            if (cfg.addr == OFS_TGT_LO) tgt_lo <= cfg.wdata;
            if (cfg.addr == OFS_TGT_HI) tgt_hi <= cfg.wdata;
        end
    end

    always_comb begin
        msg_hit   = inb.valid && (inb.addr == {tgt_hi, tgt_lo});
        fwd.valid = inb.valid && !msg_hit;
        fwd.addr  = inb.addr;
        fwd.data  = inb.data;
    end

    // R4: a non-matching write must leave the block untouched
    p_forward_untouched_r4: assert property (@(posedge clk) disable iff (rst)
        (inb.valid && (inb.addr != {tgt_hi, tgt_lo})) |->
            (fwd.valid && fwd.addr == inb.addr && fwd.data == inb.data));

    // R4: a matching write is consumed
    p_consumed_r4: assert property (@(posedge clk) disable iff (rst)
        msg_hit |-> !fwd.valid);

endmodule

// File: rtl/msi_vector_decode.sv
module msi_vector_decode
    import msi_cap_pkg::*;
#(
    parameter int NUM_BANKS = 8
)(
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  msg_hit,
    input  logic [WORD_W-1:0]                     vec_num,
    output logic [NUM_BANKS-1:0][VEC_PER_BNK-1:0] set_req
);

    localparam int SEL_W = $clog2(VEC_PER_BNK);
    localparam int HI_W  = WORD_W - SEL_W;

    logic [VEC_PER_BNK-1:0] bit_onehot;

    assign bit_onehot = VEC_PER_BNK'(1) << vec_num[SEL_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_sel
        // upper bits must equal the bank index; anything beyond the last bank matches none
        assign set_req[b] = (msg_hit && vec_num[WORD_W-1:SEL_W] == HI_W'(b)) ? bit_onehot : '0;
    end

    // R5, R9: a message requests at most one status bit in the whole block
    p_single_request_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_req));

endmodule

// File: rtl/msi_bank.sv
module msi_bank
    import msi_cap_pkg::*;
#(
    parameter int BANK_IDX = 0
)(
    input  logic                   clk,
    input  logic                   rst,
    input  reg_wr_t                regw,
    input  logic [VEC_PER_BNK-1:0] set_req,
    output logic [VEC_PER_BNK-1:0] enable,
    output logic [VEC_PER_BNK-1:0] mask,
    output logic [VEC_PER_BNK-1:0] status,
    output logic                   pending
);

    localparam logic [REG_AW-1:0] A_EN = bank_reg_ofs(BANK_IDX, FLD_ENABLE);
    localparam logic [REG_AW-1:0] A_MK = bank_reg_ofs(BANK_IDX, FLD_MASK);
    localparam logic [REG_AW-1:0] A_ST = bank_reg_ofs(BANK_IDX, FLD_STATUS);

    logic [VEC_PER_BNK-1:0] clr_bits;
    logic [VEC_PER_BNK-1:0] accept;

    assign clr_bits = (regw.we && regw.addr == A_ST) ? regw.wdata : '0;
    assign accept   = set_req & enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            mask   <= '0;
            status <= '0;
        end else begin
            if (regw.we && regw.addr == A_EN) enable <= regw.wdata;
            if (regw.we && regw.addr == A_MK) mask   <= regw.wdata;
            // clear first, then arrivals: an arrival on a bit being cleared survives
            status <= (status & ~clr_bits) | accept;
        end
    end

    assign pending = |(status & ~mask);

    // R6: a status bit only rises when its enable was set
    p_rise_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
        (status & ~$past(status) & ~$past(enable)) == '0);

    // R7: bits written as one are gone unless a vector hit them in that cycle
    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (regw.we && regw.addr == A_ST) |=> ((status & $past(regw.wdata & ~set_req)) == '0));

    // R10: an enabled arrival is always recorded, even against a clear
    p_arrival_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (set_req != '0) |=> ((~status & $past(set_req & enable)) == '0));

endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
    import msi_cap_pkg::*;
#(
    parameter int NUM_BANKS = 8
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [MADDR_W-1:0] in_addr,
    input  logic [WORD_W-1:0]  in_data,
    output logic               pass_valid,
    output logic [MADDR_W-1:0] pass_addr,
    output logic [WORD_W-1:0]  pass_data,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               irq
);

    localparam int LAST_OFS = OFS_BANK0 + BNK_STRIDE * NUM_BANKS;

    mem_wr_t inb, fwd;
    reg_wr_t regw;
    logic    msg_hit;
    logic [WORD_W-1:0] tgt_lo, tgt_hi;

    logic [NUM_BANKS-1:0][VEC_PER_BNK-1:0] set_req;
    logic [NUM_BANKS-1:0][VEC_PER_BNK-1:0] bank_en, bank_mk, bank_st;
    logic [NUM_BANKS-1:0]                  bank_pend;

    initial begin
        if (LAST_OFS > (1 << REG_AW)) $error("bank registers exceed the register window");
    end

    assign inb  = '{valid: in_valid, addr: in_addr, data: in_data};
    assign regw = '{we: reg_we, addr: reg_addr, wdata: reg_wdata};

    msi_target_match u_match (
        .clk     (clk),
        .rst     (rst),
        .cfg     (regw),
        .inb     (inb),
        .fwd     (fwd),
        .msg_hit (msg_hit),
        .tgt_lo  (tgt_lo),
        .tgt_hi  (tgt_hi)
    );

    assign pass_valid = fwd.valid;
    assign pass_addr  = fwd.addr;
    assign pass_data  = fwd.data;

    msi_vector_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
        .clk     (clk),
        .rst     (rst),
        .msg_hit (msg_hit),
        .vec_num (in_data),
        .set_req (set_req)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        msi_bank #(.BANK_IDX(b)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .regw    (regw),
            .set_req (set_req[b]),
            .enable  (bank_en[b]),
            .mask    (bank_mk[b]),
            .status  (bank_st[b]),
            .pending (bank_pend[b])
        );
    end

    assign irq = |bank_pend;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_TGT_LO) reg_rdata = tgt_lo;
        if (reg_addr == OFS_TGT_HI) reg_rdata = tgt_hi;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_addr == bank_reg_ofs(b, FLD_ENABLE)) reg_rdata = bank_en[b];
            if (reg_addr == bank_reg_ofs(b, FLD_MASK))   reg_rdata = bank_mk[b];
            if (reg_addr == bank_reg_ofs(b, FLD_STATUS)) reg_rdata = bank_st[b];
        end
    end

    // R8: the line stays low while every pending bit is masked
    p_irq_needs_unmasked_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((bank_st & ~bank_mk) != '0));

    // R1: the cycle after reset nothing is pending
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !irq);

endmodule

// File: tb/tb_msi_capture_ctrl.sv
module tb_msi_capture_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        pass_valid;
    logic [63:0] pass_addr;
    logic [31:0] pass_data;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [63:0] TGT = 64'h0000_0001_FEE0_1000;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_capture_ctrl dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
        .pass_valid(pass_valid), .pass_addr(pass_addr), .pass_data(pass_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [11:0] a_en(int b); return 12'(12'h828 + 12*b); endfunction
    function automatic logic [11:0] a_mk(int b); return 12'(12'h82C + 12*b); endfunction
    function automatic logic [11:0] a_st(int b); return 12'(12'h830 + 12*b); endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send(logic [63:0] a, logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic clear_all();
        for (int b = 0; b < 8; b++) begin
            reg_write(a_st(b), 32'hFFFF_FFFF);
            reg_write(a_en(b), 32'h0);
            reg_write(a_mk(b), 32'h0);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(12'h820, v); chk("R1", "target lo", v, 0);
        reg_read(12'h824, v); chk("R1", "target hi", v, 0);
        for (int b = 0; b < 8; b++) begin
            reg_read(a_en(b), v); chk("R1", "enable", v, 0);
            reg_read(a_mk(b), v); chk("R1", "mask", v, 0);
            reg_read(a_st(b), v); chk("R1", "status", v, 0);
        end
        chk("R1", "irq", irq, 0);
    endtask

    task automatic t_target();
        logic [31:0] v;
        reg_write(12'h820, TGT[31:0]);
        reg_write(12'h824, TGT[63:32]);
        reg_read(12'h820, v); chk("R2", "target lo", v, TGT[31:0]);
        reg_read(12'h824, v); chk("R2", "target hi", v, TGT[63:32]);
    endtask

    task automatic t_bank_regs();
        logic [31:0] v;
        reg_write(a_en(7), 32'hA5A5_0F0F);
        reg_write(a_mk(7), 32'h1234_5678);
        reg_write(a_st(7), 32'hFFFF_FFFF);
        reg_read(a_en(7), v); chk("R3", "bank7 enable", v, 32'hA5A5_0F0F);
        reg_read(a_mk(7), v); chk("R3", "bank7 mask", v, 32'h1234_5678);
        reg_read(a_st(7), v); chk("R3", "bank7 status not settable", v, 0);
        reg_read(a_en(6), v); chk("R3", "bank6 enable untouched", v, 0);
        clear_all();
    endtask

    task automatic t_match();
        logic [31:0] v;
        reg_write(a_en(3), 32'h0000_0020);
        @(negedge clk);
        in_valid = 1'b1; in_addr = TGT; in_data = 32'd101;
        #1;
        chk("R4", "matching write consumed", pass_valid, 0);
        @(negedge clk);
        in_valid = 1'b0;
        reg_read(a_st(3), v); chk("R5", "vector 101 bank3 bit5", v, 32'h0000_0020);
        chk("R8", "irq after unmasked vector", irq, 1);
        reg_write(a_en(0), 32'hFFFF_FFFF);
        @(negedge clk);
        in_valid = 1'b1; in_addr = TGT ^ 64'h0000_0002_0000_0000; in_data = 32'd7;
        #1;
        chk("R4", "forward valid", pass_valid, 1);
        chk("R4", "forward addr", pass_addr, TGT ^ 64'h0000_0002_0000_0000);
        chk("R4", "forward data", pass_data, 32'd7);
        @(negedge clk);
        in_addr = TGT ^ 64'h1; in_data = 32'd8;
        #1;
        chk("R4", "low-word mismatch forwarded", pass_valid, 1);
        @(negedge clk);
        in_valid = 1'b0;
        reg_read(a_st(0), v); chk("R4", "non-matching writes record nothing", v, 0);
        clear_all();
    endtask

    task automatic t_enable();
        logic [31:0] v;
        reg_write(a_en(1), 32'h0000_0004);
        send(TGT, 32'd33);
        reg_read(a_st(1), v); chk("R6", "disabled vector 33 dropped", v, 0);
        chk("R6", "irq stays low", irq, 0);
        send(TGT, 32'd34);
        reg_read(a_st(1), v); chk("R5", "vector 34 bank1 bit2", v, 32'h0000_0004);
        clear_all();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        reg_write(a_en(1), 32'h0000_000C);
        send(TGT, 32'd34);
        send(TGT, 32'd35);
        reg_read(a_st(1), v); chk("R5", "bits 2,3 set", v, 32'h0000_000C);
        reg_write(a_st(1), 32'h0000_0004);
        reg_read(a_st(1), v); chk("R7", "only written one cleared", v, 32'h0000_0008);
        reg_write(a_st(1), 32'h0000_0000);
        reg_read(a_st(1), v); chk("R7", "zero write no effect", v, 32'h0000_0008);
        clear_all();
    endtask

    task automatic t_irq();
        logic [31:0] v;
        reg_write(a_en(2), 32'hFFFF_FFFF);
        reg_write(a_mk(2), 32'h0000_0001);
        send(TGT, 32'd64);
        reg_read(a_st(2), v); chk("R8", "masked vector latched", v, 32'h0000_0001);
        chk("R8", "masked vector no irq", irq, 0);
        reg_write(a_mk(2), 32'h0000_0000);
        chk("R8", "unmask raises irq", irq, 1);
        reg_write(a_st(2), 32'h0000_0001);
        chk("R8", "clear drops irq", irq, 0);
        clear_all();
    endtask

    task automatic t_range();
        logic [31:0] v;
        for (int b = 0; b < 8; b++) reg_write(a_en(b), 32'hFFFF_FFFF);
        send(TGT, 32'd256);
        send(TGT, 32'd261);
        send(TGT, 32'h8000_0001);
        for (int b = 0; b < 8; b++) begin
            reg_read(a_st(b), v); chk("R9", "out-of-range vector dropped", v, 0);
        end
        chk("R9", "irq low", irq, 0);
        send(TGT, 32'd255);
        reg_read(a_st(7), v); chk("R5", "last vector 255", v, 32'h8000_0000);
        clear_all();
    endtask

    task automatic t_race();
        logic [31:0] v;
        reg_write(a_en(0), 32'hFFFF_FFFF);
        send(TGT, 32'd9);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a_st(0); reg_wdata = 32'h0000_0200;
        in_valid = 1'b1; in_addr = TGT; in_data = 32'd9;
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0;
        reg_read(a_st(0), v); chk("R10", "arrival beats clear", v, 32'h0000_0200);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a_st(0); reg_wdata = 32'h0000_0200;
        in_valid = 1'b1; in_addr = TGT; in_data = 32'd10;
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0;
        reg_read(a_st(0), v); chk("R10", "other-bit clear honoured", v, 32'h0000_0400);
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        reg_write(a_en(7), 32'hFFFF_FFFF);
        reg_read(12'h81C, v); chk("R11", "below window", v, 0);
        reg_read(12'h888, v); chk("R11", "above last bank", v, 0);
        reg_read(12'h000, v); chk("R11", "offset 0", v, 0);
        clear_all();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_target();
        t_bank_regs();
        t_match();
        t_enable();
        t_w1c();
        t_irq();
        t_range();
        t_race();
        t_unmapped();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule